// File: doc/BRIEF.md
# Shared-Space Register and SRAM Bus Decoder

This block is the host-side front end of a timekeeping device that shares one byte-wide, asynchronous-style SRAM bus with an external static RAM. The host drives a 17-bit address, active-low chip, output and write enables, and a write data byte. The lowest 64 addresses are served from an on-chip register file. Its bottom 14 entries hold clock, alarm and watchdog state, and the other 50 entries are free user bytes. Every higher address belongs to the external RAM. For those addresses the block only steers the RAM's active-low output enable.

The on-chip registers overlay the bottom 64 bytes of the attached RAM. To avoid a bus conflict, the block never enables the external RAM's outputs for an access that falls in the register window. All host controls pass through a parameterised synchroniser into a system clock domain.

A write window is open while chip enable and write enable are both low. It therefore opens on the later falling edge of the two and closes on the earlier rising edge. A register write is committed on the clock in which the closing is seen. Outputs are registered. Each one reflects the host inputs sampled SYNC_STAGES+1 clock edges earlier, which is two edges with the default setting.

Top module: `rtc_bus_front`

## Requirements
- R1: An address below 0x00040 selects on-chip register addr[5:0]. Addresses 0x00040 through 0x1FFFF select the external RAM. Both sides of the 0x3F/0x40 boundary and the top address 0x1FFFF behave accordingly.
- R2: With ce_n=0, oe_n=0, we_n=1 and an on-chip address, rdata_oe_o is 1, rdata_o holds that register's value and ram_oe_n_o is 1. This appears two clocks after the inputs are applied.
- R3: With ce_n=0, oe_n=0, we_n=1 and an external address, ram_oe_n_o is 0 and rdata_oe_o is 0.
- R4: With ce_n=1, or with ce_n=0 and oe_n=1 and we_n=1, rdata_oe_o is 0 and ram_oe_n_o is 1.
- R5: A write to an on-chip address commits when the window closes. The committed value is the last wdata_i sampled while the window was open. The window closes at the first rise of either enable, regardless of which enable fell last.
- R6: While a write window is open, rdata_oe_o is 0 and ram_oe_n_o is 1. A write to an external address changes no on-chip register, including the register that shares its low six address bits.
- R7: If we_n falls during an on-chip read, rdata_oe_o drops to 0 two clocks later.
- R8: While rst is 1, rdata_oe_o is 0 and ram_oe_n_o is 1, whatever the bus inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | 17 | Host byte address |
| ce_n_i | input | 1 | Host chip enable, active low |
| oe_n_i | input | 1 | Host output enable, active low |
| we_n_i | input | 1 | Host write enable, active low |
| wdata_i | input | 8 | Host write data |
| rdata_o | output | 8 | Register read data |
| rdata_oe_o | output | 1 | High while rdata_o must be driven onto the bus |
| ram_oe_n_o | output | 1 | External RAM output enable, active low |

## Verification
The hardest situation to reach from the ports is an external write whose low address bits alias a register, followed by a read of that register. The failure is silent unless the register already holds a known, distinct value. For this reason the stimulus first fills all 64 registers with a known pattern. It then writes 0x00040 and 0x1FFFF and reads back registers 0x00 and 0x3F.

Write windows are opened in both enable orders and closed in both orders. The data changes mid-window, so any design that commits at the start of the window, or latches data early, is caught. A read that turns into a write by a falling write enable exercises the release of the data outputs.

// File: rtl/rtc_bus_pkg.sv
package rtc_bus_pkg;
  typedef enum logic [1:0] {
    ACC_IDLE   = 2'd0,
    ACC_REG_RD = 2'd1,
    ACC_EXT_RD = 2'd2,
    ACC_WRITE  = 2'd3
  } acc_e;
endpackage

// File: rtl/rtc_bus_sync.sv
module rtc_bus_sync #(
  parameter int W = 8,
  parameter int STAGES = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] pipe [STAGES];

  for (genvar gi = 0; gi < STAGES; gi++) begin : g_stage
    if (gi == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) pipe[gi] <= RST_VAL;
        else     pipe[gi] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) pipe[gi] <= RST_VAL;
        else     pipe[gi] <= pipe[gi-1];
      end
    end
  end

  assign dout = pipe[STAGES-1];
endmodule

// File: rtl/rtc_bus_decode.sv
module rtc_bus_decode
  import rtc_bus_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int REG_AW = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              drive_o,
  output logic              ram_oe_n_o
);
  localparam int unsigned REG_N = 1 << REG_AW;
  localparam logic [ADDR_W-1:0] REG_LIMIT = ADDR_W'(REG_N);

  acc_e kind;

  always_comb begin
    kind = ACC_IDLE;
    if (!ce_n) begin
      if (!we_n)     kind = ACC_WRITE;
      else if (!oe_n) kind = (addr < REG_LIMIT) ? ACC_REG_RD : ACC_EXT_RD;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      drive_o    <= 1'b0;
      ram_oe_n_o <= 1'b1;
    end else begin
      drive_o    <= (kind == ACC_REG_RD);
      ram_oe_n_o <= (kind != ACC_EXT_RD);
    end
  end

  // R4: deselected bus leaves both drivers off next cycle
  a_r4_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    ce_n |=> (!drive_o && ram_oe_n_o));
  // R6: an open write window never enables either driver
  a_r6_write_no_drive: assert property (@(posedge clk) disable iff (rst)
    (!ce_n && !we_n) |=> (!drive_o && ram_oe_n_o));
  // R2: register read keeps the external RAM silent
  a_r2_shadow_ram: assert property (@(posedge clk) disable iff (rst)
    (!ce_n && !oe_n && we_n && addr < REG_LIMIT) |=> (drive_o && ram_oe_n_o));
  // R3: the two bus drivers are never enabled together
  always @(posedge clk) begin
    if (!rst) a_r3_exclusive: assert (!(drive_o && !ram_oe_n_o));
  end
endmodule

// File: rtl/rtc_bus_wrctl.sv
module rtc_bus_wrctl #(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8,
  parameter int REG_AW = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output logic              wr_en,
  output logic [REG_AW-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  localparam int unsigned REG_N = 1 << REG_AW;
  localparam logic [ADDR_W-1:0] REG_LIMIT = ADDR_W'(REG_N);

  logic win, win_q, onchip_q;

  assign win = !ce_n && !we_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      win_q    <= 1'b0;
      onchip_q <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else begin
      win_q <= win;
      if (win) begin
        onchip_q <= (addr < REG_LIMIT);
        wr_addr  <= addr[REG_AW-1:0];
        wr_data  <= data;
      end
    end
  end

  assign wr_en = win_q && !win && onchip_q;

  // R5: nothing commits while the window is still open
  a_r5_no_commit_open: assert property (@(posedge clk) disable iff (rst)
    win |-> !wr_en);
  // R5: one commit per window
  a_r5_single_commit: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !wr_en);
  // R6: a window on an external address commits nothing
  a_r6_ext_no_commit: assert property (@(posedge clk) disable iff (rst)
    (win && addr >= REG_LIMIT) |=> !wr_en);
endmodule

// File: rtl/rtc_bus_regfile.sv
module rtc_bus_regfile #(
  parameter int DATA_W = 8,
  parameter int REG_AW = 6
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [REG_AW-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << REG_AW;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/rtc_bus_front.sv
module rtc_bus_front #(
  parameter int ADDR_W      = 17,
  parameter int DATA_W      = 8,
  parameter int REG_AW      = 6,
  parameter int SYNC_STAGES = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              ce_n_i,
  input  logic              oe_n_i,
  input  logic              we_n_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rdata_oe_o,
  output logic              ram_oe_n_o
);
  localparam int BUS_W = 3 + ADDR_W + DATA_W;
  localparam logic [BUS_W-1:0] BUS_IDLE = {3'b111, {(ADDR_W + DATA_W){1'b0}}};

  logic [BUS_W-1:0]  bus_s;
  logic              ce_s, oe_s, we_s;
  logic [ADDR_W-1:0] addr_s;
  logic [DATA_W-1:0] data_s;
  logic              wr_en;
  logic [REG_AW-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;

  rtc_bus_sync #(.W(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL(BUS_IDLE)) u_sync (
    .clk (clk),
    .rst (rst),
    .din ({ce_n_i, oe_n_i, we_n_i, addr_i, wdata_i}),
    .dout(bus_s)
  );

  assign {ce_s, oe_s, we_s, addr_s, data_s} = bus_s;

  rtc_bus_decode #(.ADDR_W(ADDR_W), .REG_AW(REG_AW)) u_decode (
    .clk       (clk),
    .rst       (rst),
    .ce_n      (ce_s),
    .oe_n      (oe_s),
    .we_n      (we_s),
    .addr      (addr_s),
    .drive_o   (rdata_oe_o),
    .ram_oe_n_o(ram_oe_n_o)
  );

  rtc_bus_wrctl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_AW(REG_AW)) u_wrctl (
    .clk    (clk),
    .rst    (rst),
    .ce_n   (ce_s),
    .we_n   (we_s),
    .addr   (addr_s),
    .data   (data_s),
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .wr_data(wr_data)
  );

  rtc_bus_regfile #(.DATA_W(DATA_W), .REG_AW(REG_AW)) u_regs (
    .clk    (clk),
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .wr_data(wr_data),
    .rd_addr(addr_s[REG_AW-1:0]),
    .rd_data(rdata_o)
  );
endmodule

// File: tb/sim_rtc_bus_front.sv
module sim_rtc_bus_front;
  localparam int LAT = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [16:0] addr = '0;
  logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [7:0]  din = '0;
  logic [7:0]  rdata;
  logic        rdata_oe, ram_oe_n;

  int checks = 0;
  int errors = 0;
  bit model_on = 0;
  bit done = 0;
  string focus = "";

  typedef struct {
    bit        ce, oe, we;
    bit [16:0] a;
    bit [7:0]  d;
  } smp_t;

  smp_t      hist[$];
  bit [7:0]  mem [64];
  bit        prev_open = 0, w_on = 0;
  bit [5:0]  w_a = '0;
  bit [7:0]  w_d = '0;

  always #5 clk = ~clk;

  rtc_bus_front u0 (
    .clk(clk), .rst(rst), .addr_i(addr), .ce_n_i(ce_n), .oe_n_i(oe_n),
    .we_n_i(we_n), .wdata_i(din), .rdata_o(rdata), .rdata_oe_o(rdata_oe),
    .ram_oe_n_o(ram_oe_n)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s%s %s: actual=%0h expected=%0h at %0t", tag, focus, what, act, exp, $time);
    end
  endtask

  function automatic string tag_of(smp_t e);
    if (e.ce) return "R4";
    if (!e.we) return (e.a < 64) ? "R5" : "R6";
    if (!e.oe) return (e.a < 64) ? "R2" : "R3";
    return "R4";
  endfunction

  task automatic model_step();
    smp_t s, e;
    bit exp_doe, exp_ram, open;
    s.ce = ce_n; s.oe = oe_n; s.we = we_n; s.a = addr; s.d = din;
    hist.push_front(s);
    if (hist.size() < LAT) return;
    e = hist.pop_back();
    exp_doe = !e.ce && !e.oe && e.we && (e.a < 64);
    exp_ram = !(!e.ce && !e.oe && e.we && (e.a >= 64));
    chk(tag_of(e), "rdata_oe_o", int'(rdata_oe), int'(exp_doe));
    chk(tag_of(e), "ram_oe_n_o", int'(ram_oe_n), int'(exp_ram));
    if (exp_doe) chk(tag_of(e), "rdata_o", int'(rdata), int'(mem[e.a[5:0]]));
    open = !e.ce && !e.we;
    if (prev_open && !open && w_on) mem[w_a] = w_d;
    if (open) begin
      w_on = (e.a < 64);
      w_a  = e.a[5:0];
      w_d  = e.d;
    end
    prev_open = open;
  endtask

  task automatic step();
    @(negedge clk);
    if (model_on) model_step();
  endtask

  // Write with a mid-window data change; ce_first picks enable order, ce_rise_first picks closing order.
  task automatic wr(input bit [16:0] a, input bit [7:0] d, input bit ce_first, input bit ce_rise_first);
    addr = a; din = ~d;
    if (ce_first) ce_n = 1'b0; else we_n = 1'b0;
    step();
    if (ce_first) we_n = 1'b0; else ce_n = 1'b0;
    step();
    step();
    din = d;
    step();
    if (ce_rise_first) ce_n = 1'b1; else we_n = 1'b1;
    din = ~d;
    step();
    ce_n = 1'b1; we_n = 1'b1;
    step();
  endtask

  task automatic rd(input bit [16:0] a);
    addr = a; ce_n = 1'b0; oe_n = 1'b0;
    step(); step(); step();
    ce_n = 1'b1; oe_n = 1'b1;
    step();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    // R8: reset dominates an active register read on the bus
    addr = 17'h00005; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R8", "rdata_oe_o in reset", int'(rdata_oe), 0);
    chk("R8", "ram_oe_n_o in reset", int'(ram_oe_n), 1);
    addr = 17'h00045;
    @(negedge clk);
    chk("R8", "ram_oe_n_o in reset ext", int'(ram_oe_n), 1);
    ce_n = 1'b1; oe_n = 1'b1; addr = '0;
    @(negedge clk);
    rst = 1'b0;
    model_on = 1;
    idle(3);

    // Fill every register with a known pattern (R5)
    for (int i = 0; i < 64; i++) wr(17'(i), 8'(i * 7 + 3), i[0], i[1]);
    for (int i = 0; i < 64; i += 9) rd(17'(i));

    // R1: boundary and top addresses
    focus = "/R1";
    rd(17'h0003F); rd(17'h00040); rd(17'h1FFFF); rd(17'h00000);
    // R6: external writes aliasing registers 0x00 and 0x3F leave them intact
    focus = "/R6";
    wr(17'h00040, 8'hA5, 1, 1);
    wr(17'h1FFFF, 8'h5A, 0, 0);
    rd(17'h00000); rd(17'h0003F);
    // R5: on-chip boundary register, both enable orders
    focus = "/R5";
    wr(17'h0003F, 8'hC3, 0, 1);
    rd(17'h0003F);
    wr(17'h0000D, 8'h3C, 1, 0);
    rd(17'h0000D);

    // R7: write enable falls during an on-chip read
    focus = "/R7";
    addr = 17'h0000D; din = 8'h77; ce_n = 1'b0; oe_n = 1'b0;
    step(); step(); step();
    we_n = 1'b0;
    step(); step(); step();
    we_n = 1'b1;
    step();
    ce_n = 1'b1; oe_n = 1'b1;
    step();
    rd(17'h0000D);

    // R4: output enable high with chip selected, and oe low with chip idle
    focus = "/R4";
    addr = 17'h00003; ce_n = 1'b0; step(); step(); step();
    ce_n = 1'b1; oe_n = 1'b0; addr = 17'h00100; step(); step(); step();
    oe_n = 1'b1; step();

    // Mixed traffic
    focus = "";
    for (int k = 0; k < 300; k++) begin
      bit [16:0] a;
      int sel = $urandom_range(0, 5);
      case (sel)
        0: a = 17'h0003F;
        1: a = 17'h00040;
        2: a = 17'h1FFFF;
        3: a = 17'($urandom_range(0, 63));
        default: a = 17'($urandom_range(0, 17'h1FFFF));
      endcase
      if ($urandom_range(0, 1) == 1) rd(a);
      else wr(a, 8'($urandom_range(0, 255)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
    end
    idle(4);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule